// File: doc/BRIEF.md
# Duplicated-bit parity link codec

This block is the encode and decode pair for a parallel on-chip link between two switches. On the transmit side, each bit of a K-bit word drives two neighbouring wires. One more wire carries the even parity of the word. The receiving end therefore sees 2K+1 wires.

Both wires of a bit always switch in the same direction. As a result, no data wire can see both of its neighbours switching against it. The worst-case coupling on the link drops from (1+4λ)CL to (1+2λ)CL.

On the receive side, the decoder recomputes parity over the first copy of the bits. If that parity matches the received parity wire, the decoder delivers the first copy. Otherwise it delivers the second copy. This corrects any single flipped wire without any syndrome logic. A flag output marks every word where a correction or a disagreement between the copies was seen, so that upstream logic can count error events. An optional register stage on the decoder outputs trades one cycle of latency for timing.

Top module: `dap_link_codec`

## Requirements
- R1: For every data bit i, link wires 2i and 2i+1 both carry tx_data_i[i]. link_valid_o equals tx_valid_i in the same cycle.
- R2: Link wire 2K carries the even parity (XOR) of all K bits of tx_data_i.
- R3: A received word with no wire in error is delivered unchanged on rx_data_o, and rx_flag_o is 0.
- R4: When exactly one of the 2K+1 received wires is inverted, whether a first-copy wire, a second-copy wire or the parity wire, rx_data_o equals the original word.
- R5: rx_flag_o is 1 for every received word with exactly one inverted wire.
- R6: With OUT_REG=1 (the default), rx_valid_o, rx_data_o and rx_flag_o appear one clock after the word is presented on link_i with rx_valid_i. During reset they read 0.
- R7: With OUT_REG=1, a cycle with rx_valid_i low leaves rx_data_o and rx_flag_o unchanged and drives rx_valid_o low.
- R8: Between any two consecutive transmitted words, no link wire switches in the direction opposite to both of its neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Transmit word qualifier |
| tx_data_i | input | K | Word to encode |
| link_valid_o | output | 1 | Qualifier sent with the encoded word |
| link_o | output | 2K+1 | Encoded link wires |
| rx_valid_i | input | 1 | Received word qualifier |
| link_i | input | 2K+1 | Received link wires |
| rx_valid_o | output | 1 | Decoded word qualifier |
| rx_data_o | output | K | Corrected word |
| rx_flag_o | output | 1 | Correction or copy disagreement seen |

## Verification
The bench walks a single inverted wire across every one of the 65 positions. It does this on random words and on the all-zeros, all-ones and alternating words. An inverted second-copy wire leaves parity intact, so a decoder that watched parity alone would miss the event and leave the flag low. An inverted parity wire must still deliver the correct data, which would break if the decoder chose the copy by any rule other than the parity match. Idle gaps with changing transmit data catch a register stage that captures when valid is low. Each transition between alternating words is checked for the opposite-neighbour pattern that a wrong wire order would produce.

// File: rtl/dap_pkg.sv
package dap_pkg;
  function automatic int unsigned link_width(int unsigned k);
    return 2 * k + 1;
  endfunction
endpackage

// File: rtl/dap_encoder.sv
module dap_encoder #(
  parameter int unsigned K = 32,
  localparam int unsigned W = dap_pkg::link_width(K)
) (
  input  logic [K-1:0] data_i,
  output logic [W-1:0] wires_o
);
  for (genvar i = 0; i < K; i++) begin : g_pair
    assign wires_o[2*i]   = data_i[i];
    assign wires_o[2*i+1] = data_i[i];
  end
  assign wires_o[W-1] = ^data_i;
endmodule

// File: rtl/dap_decoder.sv
module dap_decoder #(
  parameter int unsigned K = 32,
  localparam int unsigned W = dap_pkg::link_width(K)
) (
  input  logic [W-1:0] wires_i,
  output logic [K-1:0] data_o,
  output logic         flag_o
);
  logic [K-1:0] copy_a, copy_b;
  logic         par_ok;

  for (genvar i = 0; i < K; i++) begin : g_split
    assign copy_a[i] = wires_i[2*i];
    assign copy_b[i] = wires_i[2*i+1];
  end

  assign par_ok = (^copy_a) == wires_i[W-1];
  // parity mismatch means copy A (or the parity wire) is hit: take copy B
  assign data_o = par_ok ? copy_a : copy_b;
  assign flag_o = !par_ok || (copy_a != copy_b);
endmodule

// File: rtl/dap_out_stage.sv
module dap_out_stage #(
  parameter int unsigned K  = 32,
  parameter bit          EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [K-1:0] data_i,
  input  logic         flag_i,
  output logic         valid_o,
  output logic [K-1:0] data_o,
  output logic         flag_o
);
  if (EN) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        data_o  <= '0;
        flag_o  <= 1'b0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) begin
          data_o <= data_i;
          flag_o <= flag_i;
        end
      end
    end
  end else begin : g_wire
    assign valid_o = valid_i;
    assign data_o  = data_i;
    assign flag_o  = flag_i;
  end
endmodule

// File: rtl/dap_link_codec.sv
module dap_link_codec #(
  parameter int unsigned K       = 32,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned W      = dap_pkg::link_width(K)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_valid_i,
  input  logic [K-1:0] tx_data_i,
  output logic         link_valid_o,
  output logic [W-1:0] link_o,
  input  logic         rx_valid_i,
  input  logic [W-1:0] link_i,
  output logic         rx_valid_o,
  output logic [K-1:0] rx_data_o,
  output logic         rx_flag_o
);
  logic [K-1:0] dec_data;
  logic         dec_flag;

  assign link_valid_o = tx_valid_i;

  dap_encoder #(.K(K)) u_enc (
    .data_i  (tx_data_i),
    .wires_o (link_o)
  );

  dap_decoder #(.K(K)) u_dec (
    .wires_i (link_i),
    .data_o  (dec_data),
    .flag_o  (dec_flag)
  );

  dap_out_stage #(.K(K), .EN(OUT_REG)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (rx_valid_i),
    .data_i  (dec_data),
    .flag_i  (dec_flag),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o),
    .flag_o  (rx_flag_o)
  );
endmodule

// File: rtl/dap_link_codec_chk.sv
module dap_link_codec_chk #(
  parameter int unsigned K       = 32,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned W      = dap_pkg::link_width(K)
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tx_valid_i,
  input logic [K-1:0] tx_data_i,
  input logic         link_valid_o,
  input logic [W-1:0] link_o,
  input logic         rx_valid_i,
  input logic [W-1:0] link_i,
  input logic         rx_valid_o,
  input logic [K-1:0] rx_data_o,
  input logic         rx_flag_o
);
  logic [K-1:0] tx_even, tx_odd, rx_even, rx_odd;
  logic         rx_clean;

  for (genvar i = 0; i < K; i++) begin : g_sel
    assign tx_even[i] = link_o[2*i];
    assign tx_odd[i]  = link_o[2*i+1];
    assign rx_even[i] = link_i[2*i];
    assign rx_odd[i]  = link_i[2*i+1];
  end
  assign rx_clean = (rx_even == rx_odd) && ((^rx_even) == link_i[W-1]);

  assert_pairs_match_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_even == tx_data_i) && (tx_odd == tx_data_i) && (link_valid_o == tx_valid_i));

  assert_parity_wire_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_o[W-1] == (^tx_even));

  if (OUT_REG) begin : g_reg_chk
    assert_valid_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_valid_o == $past(rx_valid_i));
    assert_clean_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_valid_i && rx_clean |=> !rx_flag_o && rx_data_o == $past(rx_even));
    assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rx_valid_i |=> $stable(rx_data_o) && $stable(rx_flag_o));
  end else begin : g_wire_chk
    assert_clean_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_clean |-> !rx_flag_o && rx_data_o == rx_even);
  end
endmodule

bind dap_link_codec dap_link_codec_chk #(.K(K), .OUT_REG(OUT_REG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_valid_i   (tx_valid_i),
  .tx_data_i    (tx_data_i),
  .link_valid_o (link_valid_o),
  .link_o       (link_o),
  .rx_valid_i   (rx_valid_i),
  .link_i       (link_i),
  .rx_valid_o   (rx_valid_o),
  .rx_data_o    (rx_data_o),
  .rx_flag_o    (rx_flag_o)
);

// File: tb/sim_dap_link_codec.sv
module sim_dap_link_codec;
  localparam int unsigned K = 32;
  localparam int unsigned W = 2 * K + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tx_valid = 1'b0;
  logic [K-1:0] tx_data = '0;
  logic         link_valid;
  logic [W-1:0] link_w;
  logic [W-1:0] fmask = '0;
  logic [W-1:0] link_rx;
  logic         rx_valid;
  logic [K-1:0] rx_data;
  logic         rx_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic         exp_valid = 1'b0;
  logic [K-1:0] exp_data  = '0;
  logic         exp_flag  = 1'b0;
  logic [W-1:0] prev_link = '0;

  always #5 clk = ~clk;

  assign link_rx = link_w ^ fmask;

  dap_link_codec u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tx_valid_i   (tx_valid),
    .tx_data_i    (tx_data),
    .link_valid_o (link_valid),
    .link_o       (link_w),
    .rx_valid_i   (tx_valid),
    .link_i       (link_rx),
    .rx_valid_o   (rx_valid),
    .rx_data_o    (rx_data),
    .rx_flag_o    (rx_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [K-1:0] act, input logic [K-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int dir(input logic a, input logic b);
    return (a == b) ? 0 : (b ? 1 : -1);
  endfunction

  task automatic step(input logic [K-1:0] d, input logic v, input int flip);
    logic [W-1:0] m;
    bit xt_bad;
    m = '0;
    if (flip >= 0) m[flip] = 1'b1;
    tx_data = d; tx_valid = v; fmask = m;
    #1;
    for (int i = 0; i < K; i++)
      chk(link_w[2*i] == d[i] && link_w[2*i+1] == d[i], "R1 pair", K'(link_w[2*i+:2]), K'({2{d[i]}}));
    chk(link_valid == v, "R1 valid", K'(link_valid), K'(v));
    begin
      logic p;
      p = 1'b0;
      for (int i = 0; i < K; i++) p = p ^ d[i];
      chk(link_w[W-1] == p, "R2 parity", K'(link_w[W-1]), K'(p));
    end
    xt_bad = 0;
    for (int j = 1; j < W - 1; j++) begin
      int t;
      t = dir(prev_link[j], link_w[j]);
      if (t != 0 && dir(prev_link[j-1], link_w[j-1]) == -t && dir(prev_link[j+1], link_w[j+1]) == -t)
        xt_bad = 1;
    end
    chk(!xt_bad, "R8 crosstalk", K'(xt_bad), '0);
    prev_link = link_w;
    @(posedge clk);
    exp_valid = v;
    if (v) begin
      exp_data = d;
      exp_flag = (flip >= 0);
    end
    @(negedge clk);
    chk(rx_valid == exp_valid, "R6 valid", K'(rx_valid), K'(exp_valid));
    chk(rx_data == exp_data, !v ? "R7 data hold" : (flip >= 0 ? "R4 corrected" : "R3 clean"), rx_data, exp_data);
    chk(rx_flag == exp_flag, !v ? "R7 flag hold" : (flip >= 0 ? "R5 flag" : "R3 flag"), K'(rx_flag), K'(exp_flag));
  endtask

  task automatic sweep(input logic [K-1:0] d);
    step(d, 1'b1, -1);
    for (int f = 0; f < W; f++) step(d, 1'b1, f);
  endtask

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rx_valid == 1'b0, "R6 reset valid", K'(rx_valid), '0);
    chk(rx_data == '0, "R6 reset data", rx_data, '0);
    chk(rx_flag == 1'b0, "R6 reset flag", K'(rx_flag), '0);
    rst_n = 1'b1;
    @(negedge clk);
    sweep('0);
    sweep('1);
    sweep(32'hAAAA_AAAA);
    sweep(32'h5555_5555);
    for (int n = 0; n < 4; n++) begin
      step(32'hAAAA_AAAA, 1'b1, -1);
      step(32'h5555_5555, 1'b1, -1);
    end
    for (int n = 0; n < 16; n++) begin
      sweep(K'($urandom));
      step(K'($urandom), 1'b0, -1);
      step(K'($urandom), 1'b0, n % W);
    end
    step(32'h1234_5678, 1'b1, 7);
    step(32'hFFFF_0000, 1'b0, -1);
    step(32'h0F0F_0F0F, 1'b1, W - 1);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule